// File: doc/BRIEF.md
# Shift Register Pair with FIFO Handshake

This block holds the two data shift registers of a small programmable I/O engine. The input shift register gathers bits from a chosen source and hands complete words to a receive FIFO. The output shift register is loaded from a transmit FIFO and gives out bits toward a chosen destination. Each register has a saturating shift counter. A static threshold per direction decides when the register counts as full (input side) or empty (output side). A sequencer outside the block issues one operation per cycle: shift in, shift out, push, pull or move. It drives the external operand (pin, X or Y value) on `src_data` and holds the operation for as long as `stall` is high.

Push and pull each come in a blocking form and a non-blocking form. Each also has a conditional form that acts only when the relevant counter has reached its threshold. The move operation can pass its source through a bitwise inversion or a bit reversal on the way to the input register, the output register or the result port. FIFO strobes and `stall` are combinational in the cycle of the operation. Register contents and the result port update at the next clock edge.

Top module: `shreg_fifo_unit`

## Requirements
- R1: After reset both shift registers are zero, the input count is 0, the output count is 32 (so `osr_empty` is 1), and `stall`, `rx_wr_en`, `tx_rd_en` and `out_valid` are 0.
- R2: Shift-in (op_code 1) takes n bits (op_bits, where 0 means 32) from the source selected by op_src (0 src_data, 1 zeros, 2 ISR, 3 OSR). With shift_right=1 the ISR becomes (isr>>n) with the low n source bits at the top. With shift_right=0 it becomes (isr<<n) with the low n source bits at the bottom.
- R3: Shift-out (op_code 2) to op_dst 1..7 presents the n bits taken from the OSR on `out_data` with `out_dest`=op_dst and `out_valid`=1 one cycle later. With shift_right=1 these are the low n bits and the OSR shifts right. With shift_right=0 they are the top n bits, right-justified, and the OSR shifts left.
- R4: Shift-out to op_dst 0 loads the ISR with the shifted-out value and sets the input count to n.
- R5: A push (op_code 3) that acts raises `rx_wr_en` in that cycle with `rx_wr_data` equal to the ISR. The ISR and the input count then become 0.
- R6: A push while `rx_full` is 1 never writes. If op_block=1 it raises `stall`. If op_block=0 it completes without stall and leaves the ISR unchanged.
- R7: A push with op_cond=1 acts only when the input count is at least push_thresh. Otherwise it does nothing and does not stall, even with the RX FIFO full.
- R8: A pull (op_code 4) that acts with `tx_empty`=0 raises `tx_rd_en`, loads the OSR from `tx_rd_data` and clears the output count. With `tx_empty`=1 a blocking pull stalls, and a non-blocking pull loads `src_data` (the X value) and clears the count.
- R9: A pull with op_cond=1 acts only when the output count is at least pull_thresh.
- R10: `osr_empty` is 1 exactly when the output count is at least pull_thresh.
- R11: Both counters add n per shift and saturate at 32.
- R12: Move (op_code 5) takes the op_src source. op_mod 1 inverts every bit, op_mod 2 reverses the bit order, and op_mod 0 or 3 passes the source unchanged. op_dst 0 loads the ISR and op_dst 7 loads the OSR, each clearing that register's count. Any other op_dst puts the value on the result port one cycle later.
- R13: A stalled operation changes neither shift register, and `stall` never coincides with a FIFO strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 1 shift-in, 2 shift-out, 3 push, 4 pull, 5 move, others idle |
| op_src | input | 2 | Source: 0 src_data, 1 zeros, 2 ISR, 3 OSR |
| op_dst | input | 3 | Destination: 0 ISR, 7 OSR (move), others result port |
| op_bits | input | 5 | Bit count, 0 means 32 |
| op_cond | input | 1 | Conditional push/pull (threshold gated) |
| op_block | input | 1 | Blocking push/pull |
| op_mod | input | 2 | Move modifier: 1 invert, 2 reverse |
| src_data | input | 32 | External operand (pins, X or Y) |
| shift_right | input | 1 | Static shift direction |
| push_thresh | input | 6 | Static input threshold, 1..32 |
| pull_thresh | input | 6 | Static output threshold, 1..32 |
| rx_full | input | 1 | RX FIFO full |
| rx_wr_en | output | 1 | RX FIFO write strobe |
| rx_wr_data | output | 32 | RX FIFO write data |
| tx_empty | input | 1 | TX FIFO empty |
| tx_rd_en | output | 1 | TX FIFO read strobe (show-ahead data) |
| tx_rd_data | input | 32 | TX FIFO head word |
| stall | output | 1 | Operation must be held |
| osr_empty | output | 1 | Output count at or above pull_thresh |
| out_valid | output | 1 | Result port valid |
| out_data | output | 32 | Shifted-out or moved value |
| out_dest | output | 3 | Destination code of the result |

## Verification
`stall`, `rx_wr_en`, `rx_wr_data` and `tx_rd_en` are due in the cycle of the operation. The bench drives each operation on the falling edge and samples these outputs 1 ns later, before the rising edge. Register contents, `osr_empty` and the result port (`out_valid`, `out_data`, `out_dest`) change at the rising edge that accepts the operation. The bench samples them 1 ns after that edge. Register contents are read back through a move to the result port, which is itself due one edge later. The sweeps cover every bit count in both directions against a bitwise model.

// File: rtl/shu_pkg.sv
package shu_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_SHIN = 3'd1,
    OP_SHOUT = 3'd2,
    OP_PUSH = 3'd3,
    OP_PULL = 3'd4,
    OP_MOV = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_ZERO = 2'd1,
    SRC_ISR = 2'd2,
    SRC_OSR = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    MOD_PASS = 2'd0,
    MOD_INV = 2'd1,
    MOD_REV = 2'd2,
    MOD_PASS2 = 2'd3
  } mod_e;

  localparam logic [2:0] DST_ISR = 3'd0;
  localparam logic [2:0] DST_OSR = 3'd7;
endpackage

// File: rtl/shu_mov_xform.sv
module shu_mov_xform #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        mod,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  import shu_pkg::*;

  logic [DATA_W-1:0] rev;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev[i] = din[DATA_W-1-i];
  end

  always_comb begin
    unique case (mod_e'(mod))
      MOD_INV: dout = ~din;
      MOD_REV: dout = rev;
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/shu_in_path.sv
module shu_in_path #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_right,
  input  logic [CNT_W-1:0]  push_thresh,
  input  logic              do_shift,
  input  logic [CNT_W-1:0]  shift_n,
  input  logic [DATA_W-1:0] shift_data,
  input  logic              do_load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              do_push,
  input  logic              push_cond,
  input  logic              push_block,
  input  logic              rx_full,
  output logic              push_stall,
  output logic              wr_en,
  output logic [DATA_W-1:0] isr_q,
  output logic [CNT_W-1:0]  cnt_q
);
  localparam logic [CNT_W:0] SAT_X = (CNT_W + 1)'(DATA_W);

  logic [DATA_W-1:0]   isr_d;
  logic [CNT_W-1:0]    cnt_d;
  logic                reg_en;
  logic [2*DATA_W-1:0] sh_r;
  logic [2*DATA_W-1:0] sh_l;
  logic [CNT_W:0]      cnt_sum;
  logic                below_thr;

  // shifted register values for both directions
  always_comb begin
    sh_r = {shift_data, isr_q} >> shift_n;
    sh_l = {isr_q, shift_data << (DATA_W - int'(shift_n))} << shift_n;
    cnt_sum = {1'b0, cnt_q} + {1'b0, shift_n};
    below_thr = push_cond && (cnt_q < push_thresh);
  end

  always_comb begin
    isr_d = isr_q;
    cnt_d = cnt_q;
    push_stall = 1'b0;
    wr_en = 1'b0;
    if (do_shift) begin
      isr_d = shift_right ? sh_r[DATA_W-1:0] : sh_l[2*DATA_W-1:DATA_W];
      cnt_d = (cnt_sum > SAT_X) ? CNT_W'(DATA_W) : cnt_sum[CNT_W-1:0];
    end else if (do_load) begin
      isr_d = load_data;
      cnt_d = load_cnt;
    end else if (do_push && !below_thr) begin
      if (rx_full) begin
        push_stall = push_block;
      end else begin
        wr_en = 1'b1;
        isr_d = '0;
        cnt_d = '0;
      end
    end
  end

  assign reg_en = do_shift || do_load || wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      cnt_q <= '0;
    end else if (reg_en) begin
      isr_q <= isr_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/shu_out_path.sv
module shu_out_path #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_right,
  input  logic [CNT_W-1:0]  pull_thresh,
  input  logic              do_shift,
  input  logic [CNT_W-1:0]  shift_n,
  output logic [DATA_W-1:0] shift_out,
  input  logic              do_load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              do_pull,
  input  logic              pull_cond,
  input  logic              pull_block,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [DATA_W-1:0] nb_data,
  output logic              pull_stall,
  output logic              rd_en,
  output logic              empty,
  output logic [DATA_W-1:0] osr_q,
  output logic [CNT_W-1:0]  cnt_q
);
  localparam logic [CNT_W:0] SAT_X = (CNT_W + 1)'(DATA_W);

  logic [DATA_W-1:0]   osr_d;
  logic [CNT_W-1:0]    cnt_d;
  logic                reg_en;
  logic [2*DATA_W-1:0] sh_r;
  logic [2*DATA_W-1:0] sh_l;
  logic [CNT_W:0]      cnt_sum;
  logic                below_thr;
  logic                nb_load;

  always_comb begin
    sh_r = {osr_q, {DATA_W{1'b0}}} >> shift_n;
    sh_l = {{DATA_W{1'b0}}, osr_q} << shift_n;
    cnt_sum = {1'b0, cnt_q} + {1'b0, shift_n};
    below_thr = pull_cond && (cnt_q < pull_thresh);
    if (shift_right) begin
      shift_out = sh_r[DATA_W-1:0] >> (DATA_W - int'(shift_n));
    end else begin
      shift_out = sh_l[2*DATA_W-1:DATA_W];
    end
  end

  always_comb begin
    osr_d = osr_q;
    cnt_d = cnt_q;
    pull_stall = 1'b0;
    rd_en = 1'b0;
    nb_load = 1'b0;
    if (do_shift) begin
      osr_d = shift_right ? sh_r[2*DATA_W-1:DATA_W] : sh_l[DATA_W-1:0];
      cnt_d = (cnt_sum > SAT_X) ? CNT_W'(DATA_W) : cnt_sum[CNT_W-1:0];
    end else if (do_load) begin
      osr_d = load_data;
      cnt_d = '0;
    end else if (do_pull && !below_thr) begin
      if (!tx_empty) begin
        rd_en = 1'b1;
        osr_d = tx_data;
        cnt_d = '0;
      end else if (pull_block) begin
        pull_stall = 1'b1;
      end else begin
        nb_load = 1'b1;
        osr_d = nb_data;
        cnt_d = '0;
      end
    end
  end

  assign reg_en = do_shift || do_load || rd_en || nb_load;
  assign empty = (cnt_q >= pull_thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osr_q <= '0;
      cnt_q <= CNT_W'(DATA_W);
    end else if (reg_en) begin
      osr_q <= osr_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/shreg_fifo_unit.sv
module shreg_fifo_unit #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int BITS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [1:0]        op_src,
  input  logic [2:0]        op_dst,
  input  logic [BITS_W-1:0] op_bits,
  input  logic              op_cond,
  input  logic              op_block,
  input  logic [1:0]        op_mod,
  input  logic [DATA_W-1:0] src_data,
  input  logic              shift_right,
  input  logic [CNT_W-1:0]  push_thresh,
  input  logic [CNT_W-1:0]  pull_thresh,
  input  logic              rx_full,
  output logic              rx_wr_en,
  output logic [DATA_W-1:0] rx_wr_data,
  input  logic              tx_empty,
  output logic              tx_rd_en,
  input  logic [DATA_W-1:0] tx_rd_data,
  output logic              stall,
  output logic              osr_empty,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [2:0]        out_dest
);
  import shu_pkg::*;

  op_e               op;
  logic [CNT_W-1:0]  n_eff;
  logic [DATA_W-1:0] src_val;
  logic [DATA_W-1:0] mov_val;
  logic [DATA_W-1:0] shout_val;
  logic [DATA_W-1:0] isr_q;
  logic [DATA_W-1:0] osr_q;
  logic [CNT_W-1:0]  isr_cnt;
  logic [CNT_W-1:0]  osr_cnt;
  logic              do_shin, do_shout, do_push, do_pull, do_mov;
  logic              isr_load, osr_load;
  logic [DATA_W-1:0] isr_load_val;
  logic [CNT_W-1:0]  isr_load_cnt;
  logic              push_stall, pull_stall;
  logic              res_valid_d, res_en;
  logic [DATA_W-1:0] res_data_d;
  logic [2:0]        res_dest_d;

  // operation decode
  always_comb begin
    op = op_e'(op_code);
    n_eff = (op_bits == '0) ? CNT_W'(DATA_W) : CNT_W'(op_bits);
    do_shin = op_valid && (op == OP_SHIN);
    do_shout = op_valid && (op == OP_SHOUT);
    do_push = op_valid && (op == OP_PUSH);
    do_pull = op_valid && (op == OP_PULL);
    do_mov = op_valid && (op == OP_MOV);
    unique case (src_e'(op_src))
      SRC_EXT: src_val = src_data;
      SRC_ZERO: src_val = '0;
      SRC_ISR: src_val = isr_q;
      default: src_val = osr_q;
    endcase
  end

  shu_mov_xform #(.DATA_W(DATA_W)) xform_i (
    .mod(op_mod),
    .din(src_val),
    .dout(mov_val)
  );

  // register load routing
  always_comb begin
    isr_load = (do_shout || do_mov) && (op_dst == DST_ISR);
    osr_load = do_mov && (op_dst == DST_OSR);
    isr_load_val = do_shout ? shout_val : mov_val;
    isr_load_cnt = do_shout ? n_eff : '0;
  end

  shu_in_path #(.DATA_W(DATA_W)) in_i (
    .clk(clk),
    .rst_n(rst_n),
    .shift_right(shift_right),
    .push_thresh(push_thresh),
    .do_shift(do_shin),
    .shift_n(n_eff),
    .shift_data(src_val),
    .do_load(isr_load),
    .load_data(isr_load_val),
    .load_cnt(isr_load_cnt),
    .do_push(do_push),
    .push_cond(op_cond),
    .push_block(op_block),
    .rx_full(rx_full),
    .push_stall(push_stall),
    .wr_en(rx_wr_en),
    .isr_q(isr_q),
    .cnt_q(isr_cnt)
  );

  shu_out_path #(.DATA_W(DATA_W)) out_i (
    .clk(clk),
    .rst_n(rst_n),
    .shift_right(shift_right),
    .pull_thresh(pull_thresh),
    .do_shift(do_shout),
    .shift_n(n_eff),
    .shift_out(shout_val),
    .do_load(osr_load),
    .load_data(mov_val),
    .do_pull(do_pull),
    .pull_cond(op_cond),
    .pull_block(op_block),
    .tx_empty(tx_empty),
    .tx_data(tx_rd_data),
    .nb_data(src_data),
    .pull_stall(pull_stall),
    .rd_en(tx_rd_en),
    .empty(osr_empty),
    .osr_q(osr_q),
    .cnt_q(osr_cnt)
  );

  assign rx_wr_data = isr_q;
  assign stall = push_stall || pull_stall;

  // result port next state
  always_comb begin
    res_valid_d = 1'b0;
    res_data_d = shout_val;
    res_dest_d = op_dst;
    if (do_shout && (op_dst != DST_ISR)) begin
      res_valid_d = 1'b1;
    end else if (do_mov && (op_dst != DST_ISR) && (op_dst != DST_OSR)) begin
      res_valid_d = 1'b1;
      res_data_d = mov_val;
    end
    res_en = res_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= res_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_dest <= '0;
    end else if (res_en) begin
      out_data <= res_data_d;
      out_dest <= res_dest_d;
    end
  end
endmodule

// File: rtl/shu_chk.sv
module shu_chk #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              stall,
  input logic              rx_full,
  input logic              rx_wr_en,
  input logic              tx_empty,
  input logic              tx_rd_en,
  input logic              out_valid,
  input logic [DATA_W-1:0] isr_q,
  input logic [DATA_W-1:0] osr_q,
  input logic [CNT_W-1:0]  isr_cnt,
  input logic [CNT_W-1:0]  osr_cnt
);
  // R6
  rx_no_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_en |-> !rx_full);

  // R8
  tx_no_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rd_en |-> !tx_empty);

  // R13
  stall_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!rx_wr_en && !tx_rd_en));

  // R13
  stall_hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(isr_q) && $stable(osr_q)));

  // R5
  push_clears_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_en |=> ((isr_q == '0) && (isr_cnt == '0)));

  // R8
  pull_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rd_en |=> (osr_cnt == '0));

  // R11
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_cnt <= CNT_W'(DATA_W)) && (osr_cnt <= CNT_W'(DATA_W)));

  // R3
  result_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(op_valid));
endmodule

bind shreg_fifo_unit shu_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/shreg_fifo_unit_tb_top.sv
module shreg_fifo_unit_tb_top;
  localparam logic [2:0] C_SHIN = 3'd1, C_SHOUT = 3'd2, C_PUSH = 3'd3,
                         C_PULL = 3'd4, C_MOV = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [1:0]  op_src;
  logic [2:0]  op_dst;
  logic [4:0]  op_bits;
  logic        op_cond, op_block;
  logic [1:0]  op_mod;
  logic [31:0] src_data;
  logic        shift_right;
  logic [5:0]  push_thresh, pull_thresh;
  logic        rx_full, rx_wr_en;
  logic [31:0] rx_wr_data;
  logic        tx_empty, tx_rd_en;
  logic [31:0] tx_rd_data;
  logic        stall, osr_empty, out_valid;
  logic [31:0] out_data;
  logic [2:0]  out_dest;

  int n_run = 0;
  int n_fail = 0;

  logic        c_stall, c_wr, c_rd;
  logic [31:0] c_wdata;
  logic        r_valid, r_empty;
  logic [31:0] r_data;
  logic [2:0]  r_dest;
  logic [31:0] m_isr, m_osr, v, e;

  always #2 clk = ~clk;

  shreg_fifo_unit dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_op(input logic [2:0] code, input logic [1:0] src,
                       input logic [2:0] dst, input int n, input logic cond,
                       input logic blk, input logic [1:0] md);
    op_valid = 1'b1; op_code = code; op_src = src; op_dst = dst;
    op_bits = 5'(n % 32); op_cond = cond; op_block = blk; op_mod = md;
    #1;
    c_stall = stall; c_wr = rx_wr_en; c_rd = tx_rd_en; c_wdata = rx_wr_data;
    @(posedge clk); #1;
    r_valid = out_valid; r_data = out_data; r_dest = out_dest; r_empty = osr_empty;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] src, output logic [31:0] val);
    do_op(C_MOV, src, 3'd1, 32, 1'b0, 1'b0, 2'd0);
    val = r_data;
  endtask

  function automatic logic [31:0] m_shin(input logic [31:0] r, input logic [31:0] d,
                                         input int n, input logic right);
    for (int k = 0; k < n; k++) begin
      if (right) r = {d[k], r[31:1]};
      else r = {r[30:0], d[n-1-k]};
    end
    return r;
  endfunction

  function automatic logic [31:0] m_shout(inout logic [31:0] r, input int n,
                                          input logic right);
    logic [31:0] d = '0;
    for (int k = 0; k < n; k++) begin
      if (right) begin d[k] = r[0]; r = {1'b0, r[31:1]}; end
      else begin d = {d[30:0], r[31]}; r = {r[30:0], 1'b0}; end
    end
    return d;
  endfunction

  function automatic logic [31:0] bitrev(input logic [31:0] x);
    logic [31:0] y;
    for (int k = 0; k < 32; k++) y[k] = x[31-k];
    return y;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_src = '0; op_dst = '0;
    op_bits = '0; op_cond = 1'b0; op_block = 1'b0; op_mod = '0; src_data = '0;
    shift_right = 1'b1; push_thresh = 6'd32; pull_thresh = 6'd32;
    rx_full = 1'b0; tx_empty = 1'b1; tx_rd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 strobes", {29'd0, stall, rx_wr_en, tx_rd_en}, 32'd0);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 osr_empty", {31'd0, osr_empty}, 32'd1);
    read_reg(2'd2, v); chk("R1 isr", v, 32'd0);
    read_reg(2'd3, v); chk("R1 osr", v, 32'd0);

    // R2 shift-in sweep, both directions, all counts
    for (int dir = 0; dir < 2; dir++) begin
      shift_right = dir[0];
      do_op(C_MOV, 2'd1, 3'd0, 32, 1'b0, 1'b0, 2'd0);
      m_isr = '0;
      for (int n = 1; n <= 32; n++) begin
        src_data = 32'h9E37_79B9 * n + 32'h1357;
        do_op(C_SHIN, 2'd0, 3'd0, n, 1'b0, 1'b0, 2'd0);
        m_isr = m_shin(m_isr, src_data, n, dir[0]);
        read_reg(2'd2, v); chk("R2 shift-in", v, m_isr);
      end
    end
    // R2 other sources: zeros, ISR, OSR
    shift_right = 1'b0;
    do_op(C_SHIN, 2'd1, 3'd0, 8, 1'b0, 1'b0, 2'd0);
    m_isr = m_shin(m_isr, 32'd0, 8, 1'b0);
    read_reg(2'd2, v); chk("R2 src zero", v, m_isr);
    do_op(C_SHIN, 2'd2, 3'd0, 12, 1'b0, 1'b0, 2'd0);
    m_isr = m_shin(m_isr, m_isr, 12, 1'b0);
    read_reg(2'd2, v); chk("R2 src isr", v, m_isr);
    src_data = 32'hCAFE_F00D;
    do_op(C_MOV, 2'd0, 3'd7, 32, 1'b0, 1'b0, 2'd0);
    m_osr = 32'hCAFE_F00D;
    do_op(C_SHIN, 2'd3, 3'd0, 20, 1'b0, 1'b0, 2'd0);
    m_isr = m_shin(m_isr, m_osr, 20, 1'b0);
    read_reg(2'd2, v); chk("R2 src osr", v, m_isr);

    // R3 / R8 shift-out sweep with pulls
    tx_empty = 1'b0;
    for (int dir = 0; dir < 2; dir++) begin
      shift_right = dir[0];
      for (int n = 1; n <= 32; n++) begin
        tx_rd_data = 32'h7F4A_7C15 ^ (32'h0101_0101 * n);
        do_op(C_PULL, 2'd0, 3'd0, 32, 1'b0, 1'b1, 2'd0);
        chk("R8 pull strobe", {31'd0, c_rd}, 32'd1);
        m_osr = tx_rd_data;
        do_op(C_SHOUT, 2'd0, 3'(1 + n % 6), n, 1'b0, 1'b0, 2'd0);
        e = m_shout(m_osr, n, dir[0]);
        chk("R3 data", r_data, e);
        chk("R3 valid/dest", {28'd0, r_valid, r_dest}, {28'd0, 1'b1, 3'(1 + n % 6)});
        read_reg(2'd3, v); chk("R3 osr rest", v, m_osr);
      end
    end
    tx_empty = 1'b1;

    // R4 shift-out into ISR; count n=12 seen via conditional push
    shift_right = 1'b1; push_thresh = 6'd12;
    do_op(C_SHOUT, 2'd0, 3'd0, 12, 1'b0, 1'b0, 2'd0);
    e = m_shout(m_osr, 12, 1'b1);
    chk("R4 no result", {31'd0, r_valid}, 32'd0);
    read_reg(2'd2, v); chk("R4 isr loaded", v, e);
    do_op(C_PUSH, 2'd0, 3'd0, 32, 1'b1, 1'b0, 2'd0);
    // R5 push
    chk("R4/R5 push write", {31'd0, c_wr}, 32'd1);
    chk("R5 push data", c_wdata, e);
    read_reg(2'd2, v); chk("R5 isr cleared", v, 32'd0);

    // R6 push to full FIFO
    src_data = 32'h1234_5678; push_thresh = 6'd32;
    do_op(C_MOV, 2'd0, 3'd0, 32, 1'b0, 1'b0, 2'd0);
    rx_full = 1'b1;
    do_op(C_PUSH, 2'd0, 3'd0, 32, 1'b0, 1'b1, 2'd0);
    chk("R6 block stall", {30'd0, c_stall, c_wr}, 32'd2);
    do_op(C_PUSH, 2'd0, 3'd0, 32, 1'b0, 1'b0, 2'd0);
    chk("R6 noblock", {30'd0, c_stall, c_wr}, 32'd0);
    read_reg(2'd2, v); chk("R6/R13 isr kept", v, 32'h1234_5678);

    // R7 conditional push
    push_thresh = 6'd8; shift_right = 1'b0;
    do_op(C_MOV, 2'd1, 3'd0, 32, 1'b0, 1'b0, 2'd0);
    src_data = 32'h0000_000A;
    do_op(C_SHIN, 2'd0, 3'd0, 4, 1'b0, 1'b0, 2'd0);
    do_op(C_PUSH, 2'd0, 3'd0, 32, 1'b1, 1'b1, 2'd0);
    chk("R7 below thr, full, no stall", {30'd0, c_stall, c_wr}, 32'd0);
    rx_full = 1'b0;
    do_op(C_PUSH, 2'd0, 3'd0, 32, 1'b1, 1'b1, 2'd0);
    chk("R7 below thr no write", {31'd0, c_wr}, 32'd0);
    src_data = 32'h0000_0005;
    do_op(C_SHIN, 2'd0, 3'd0, 4, 1'b0, 1'b0, 2'd0);
    do_op(C_PUSH, 2'd0, 3'd0, 32, 1'b1, 1'b1, 2'd0);
    chk("R7 at thr write", {31'd0, c_wr}, 32'd1);
    chk("R7 data", c_wdata, 32'h0000_00A5);

    // R11 saturation: 32+32 stays 32, so threshold 32 passes
    push_thresh = 6'd32; src_data = 32'hFFFF_0000;
    do_op(C_SHIN, 2'd0, 3'd0, 32, 1'b0, 1'b0, 2'd0);
    do_op(C_SHIN, 2'd0, 3'd0, 32, 1'b0, 1'b0, 2'd0);
    do_op(C_PUSH, 2'd0, 3'd0, 32, 1'b1, 1'b0, 2'd0);
    chk("R11 sat push", {31'd0, c_wr}, 32'd1);

    // R8 pull from empty FIFO
    tx_empty = 1'b1; src_data = 32'hDEAD_BEEF;
    do_op(C_PULL, 2'd0, 3'd0, 32, 1'b0, 1'b1, 2'd0);
    chk("R8 block stall", {30'd0, c_stall, c_rd}, 32'd2);
    read_reg(2'd3, v); chk("R8/R13 osr kept", v, m_osr);
    do_op(C_PULL, 2'd0, 3'd0, 32, 1'b0, 1'b0, 2'd0);
    chk("R8 noblock", {30'd0, c_stall, c_rd}, 32'd0);
    read_reg(2'd3, v); chk("R8 osr gets X", v, 32'hDEAD_BEEF);

    // R9 / R10 conditional pull and empty flag
    pull_thresh = 6'd16; tx_empty = 1'b0; tx_rd_data = 32'h0F0F_3C3C;
    do_op(C_PULL, 2'd0, 3'd0, 32, 1'b0, 1'b1, 2'd0);
    chk("R10 not empty", {31'd0, r_empty}, 32'd0);
    do_op(C_PULL, 2'd0, 3'd0, 32, 1'b1, 1'b1, 2'd0);
    chk("R9 below thr no read", {30'd0, c_stall, c_rd}, 32'd0);
    do_op(C_SHOUT, 2'd0, 3'd1, 8, 1'b0, 1'b0, 2'd0);
    chk("R10 count 8", {31'd0, r_empty}, 32'd0);
    do_op(C_SHOUT, 2'd0, 3'd1, 8, 1'b0, 1'b0, 2'd0);
    chk("R10 count 16", {31'd0, r_empty}, 32'd1);
    do_op(C_PULL, 2'd0, 3'd0, 32, 1'b1, 1'b1, 2'd0);
    chk("R9 at thr read", {31'd0, c_rd}, 32'd1);
    tx_empty = 1'b1;

    // R12 move modifiers and destinations
    src_data = 32'h8000_00F1;
    do_op(C_MOV, 2'd0, 3'd3, 32, 1'b0, 1'b0, 2'd1);
    chk("R12 invert", r_data, 32'h7FFF_FF0E);
    chk("R12 dest", {29'd0, r_dest}, 32'd3);
    do_op(C_MOV, 2'd0, 3'd2, 32, 1'b0, 1'b0, 2'd2);
    chk("R12 reverse", r_data, bitrev(32'h8000_00F1));
    do_op(C_MOV, 2'd0, 3'd2, 32, 1'b0, 1'b0, 2'd3);
    chk("R12 mod3 pass", r_data, 32'h8000_00F1);
    pull_thresh = 6'd1;
    do_op(C_SHOUT, 2'd0, 3'd1, 4, 1'b0, 1'b0, 2'd0);
    do_op(C_MOV, 2'd0, 3'd7, 32, 1'b0, 1'b0, 2'd2);
    chk("R12 osr count cleared", {31'd0, r_empty}, 32'd0);
    read_reg(2'd3, v); chk("R12 osr reversed", v, bitrev(32'h8000_00F1));
    do_op(C_MOV, 2'd3, 3'd0, 32, 1'b0, 1'b0, 2'd1);
    read_reg(2'd2, v); chk("R12 isr inverted osr", v, ~bitrev(32'h8000_00F1));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule